// File: doc/BRIEF.md
# GPIO Controller with Edge-Cause Interrupts

This block is a register-mapped general purpose I/O controller for a parameterised number of pins, at most 32. Software drives pins by writing masks into two separate windows. One window only turns bits on and the other only turns bits off, so a single write changes a chosen set of output-enable or data-out bits and software never has to read a register first.

Pad inputs pass through a synchronizer. Each pin can record a cause on a rising edge, a falling edge, or both, as chosen by two enable masks. The latched causes are gated by an event-enable mask. The gated result is read back as one register and is also ORed into a single registered interrupt line.

A synchronous register bus selects one of four regions (main, cause, set, clear) plus a byte offset. Reads return data one cycle after the request.

Top module: `gpio_ec_top`

## Requirements
- R1: After reset every readable register is zero, `pad_oe` and `pad_out` are zero and `irq` is low.
- R2: A write to region 2 (set) at offset 0x00 sets the output-enable bits where the data is 1, and at offset 0x04 it sets the data-out bits in the same way. Bits written as 0 keep their value.
- R3: A write to region 3 (clear) at offset 0x00 clears the output-enable bits where the data is 1, and at offset 0x04 it clears the data-out bits in the same way. Bits written as 0 keep their value. Either window reads output-enable at 0x00 and data-out at 0x04.
- R4: `pad_out[i]` equals data-out bit i while output-enable bit i is 1, and is 0 otherwise. `pad_oe` mirrors the output-enable register.
- R5: Region 0 (main) offset 0x08 reads the pin levels after a two-flop synchronizer. A read issued in the same cycle a pad changes still returns the old level.
- R6: Region 0 offset 0x00 is the rising-edge enable and offset 0x04 is the falling-edge enable, both read/write. A pin latches a cause bit on a synchronized edge of an enabled direction.
- R7: A pin with both its rise and fall enables set latches a cause on either edge.
- R8: Region 1 (cause) offset 0x14 is a read/write event-enable mask. Offset 0x00 reads the latched causes ANDed with that mask, and masked causes stay latched underneath.
- R9: Writing 1s to region 1 offset 0x18 clears the matching cause bits. If a new edge reaches a bit in the same cycle as its clear, the bit stays set.
- R10: `irq` is high one cycle after any cause bit is set with its event-enable bit set, and low one cycle after none is.
- R11: Register bits at or above the pin count read as zero and ignore writes.
- R12: `bus_rdata` takes the read result at the clock edge that samples a read request and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_region | input | 2 | 0 main, 1 cause, 2 set, 3 clear |
| bus_addr | input | 8 | Byte offset in the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Registered data to the pad drivers |
| pad_oe | output | NPINS | Registered output enables |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume at most one bus access per cycle and no bus traffic while reset is high. They also take the unconnected upper bits of write data to be ignored rather than constrained. The random phase holds the pads static, so config writes cannot create causes while it changes windows and masks freely. The edge phase then moves pads at known cycles, so the bench can place a clear write in the exact cycle an edge arrives.

// File: rtl/gpio_ec_pkg.sv
package gpio_ec_pkg;
  typedef enum logic [1:0] {
    WIN_MAIN  = 2'd0,
    WIN_CAUSE = 2'd1,
    WIN_SET   = 2'd2,
    WIN_CLR   = 2'd3
  } win_e;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LEVEL    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CAUSE_RD = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EVT_EN   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CAUSE_CL = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_OE       = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DOUT     = 8'h04;
endpackage

// File: rtl/gpio_ec_sync.sv
module gpio_ec_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_ec_cause.sv
module gpio_ec_cause #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] cause_q
);
  logic [W-1:0] prev_q;

  always_comb begin
    edge_hit = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= level;
      // a fresh edge outranks a clear aimed at the same bit
      cause_q <= (cause_q & ~clr_mask) | edge_hit;
    end
  end
endmodule

// File: rtl/gpio_ec_outreg.sv
module gpio_ec_outreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] oe_set,
  input  logic [W-1:0] oe_clr,
  input  logic [W-1:0] do_set,
  input  logic [W-1:0] do_clr,
  output logic [W-1:0] oe_q,
  output logic [W-1:0] do_q,
  output logic [W-1:0] pad_out_q
);
  logic [W-1:0] oe_n, do_n;

  always_comb begin
    oe_n = (oe_q | oe_set) & ~oe_clr;
    do_n = (do_q | do_set) & ~do_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q      <= '0;
      do_q      <= '0;
      pad_out_q <= '0;
    end else begin
      oe_q      <= oe_n;
      do_q      <= do_n;
      pad_out_q <= do_n & oe_n;
    end
  end
endmodule

// File: rtl/gpio_ec_top.sv
module gpio_ec_top
  import gpio_ec_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [1:0]        bus_region,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int W = NPINS;

  win_e         win;
  logic         wr_en, rd_en;
  logic [W-1:0] wd;
  logic [W-1:0] level, rise_en_q, fall_en_q, evten_q;
  logic [W-1:0] cause_q, edge_hit, clr_mask;
  logic [W-1:0] oe_set, oe_clr, do_set, do_clr, oe_q, do_q;
  logic [BUS_W-1:0] rd_val;

  assign win   = win_e'(bus_region);
  assign wr_en = bus_req & bus_wr;
  assign rd_en = bus_req & ~bus_wr;
  assign wd    = bus_wdata[W-1:0];

  function automatic logic [BUS_W-1:0] zext(input logic [W-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[W-1:0] = v;
    return r;
  endfunction

  gpio_ec_sync #(.W(W), .STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .d(pad_in), .q(level)
  );

  always_comb begin
    oe_set   = '0;
    oe_clr   = '0;
    do_set   = '0;
    do_clr   = '0;
    clr_mask = '0;
    if (wr_en) begin
      unique case (win)
        WIN_SET: begin
          if (bus_addr == OFS_OE)   oe_set = wd;
          if (bus_addr == OFS_DOUT) do_set = wd;
        end
        WIN_CLR: begin
          if (bus_addr == OFS_OE)   oe_clr = wd;
          if (bus_addr == OFS_DOUT) do_clr = wd;
        end
        WIN_CAUSE: if (bus_addr == OFS_CAUSE_CL) clr_mask = wd;
        default: ;
      endcase
    end
  end

  gpio_ec_outreg #(.W(W)) out_i (
    .clk(clk), .rst(rst),
    .oe_set(oe_set), .oe_clr(oe_clr), .do_set(do_set), .do_clr(do_clr),
    .oe_q(oe_q), .do_q(do_q), .pad_out_q(pad_out)
  );
  assign pad_oe = oe_q;

  gpio_ec_cause #(.W(W)) cause_i (
    .clk(clk), .rst(rst), .level(level),
    .rise_en(rise_en_q), .fall_en(fall_en_q), .clr_mask(clr_mask),
    .edge_hit(edge_hit), .cause_q(cause_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      evten_q   <= '0;
    end else if (wr_en) begin
      if (win == WIN_MAIN  && bus_addr == OFS_RISE_EN) rise_en_q <= wd;
      if (win == WIN_MAIN  && bus_addr == OFS_FALL_EN) fall_en_q <= wd;
      if (win == WIN_CAUSE && bus_addr == OFS_EVT_EN)  evten_q   <= wd;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (win)
      WIN_MAIN: begin
        if (bus_addr == OFS_RISE_EN) rd_val = zext(rise_en_q);
        if (bus_addr == OFS_FALL_EN) rd_val = zext(fall_en_q);
        if (bus_addr == OFS_LEVEL)   rd_val = zext(level);
      end
      WIN_CAUSE: begin
        if (bus_addr == OFS_CAUSE_RD) rd_val = zext(cause_q & evten_q);
        if (bus_addr == OFS_EVT_EN)   rd_val = zext(evten_q);
      end
      default: begin
        if (bus_addr == OFS_OE)   rd_val = zext(oe_q);
        if (bus_addr == OFS_DOUT) rd_val = zext(do_q);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd_en) bus_rdata <= rd_val;
      irq <= |(cause_q & evten_q);
    end
  end
endmodule

// File: rtl/gpio_ec_chk.sv
module gpio_ec_chk
  import gpio_ec_pkg::*;
#(
  parameter int NPINS = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [1:0]        bus_region,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq,
  input logic [NPINS-1:0]  cause_q,
  input logic [NPINS-1:0]  evten_q,
  input logic [NPINS-1:0]  edge_hit,
  input logic [NPINS-1:0]  clr_mask
);
  logic live_q;
  always_ff @(posedge clk) live_q <= ~rst;

  AST_OE_SET_WIN: assert property (@(posedge clk) disable iff (rst || !live_q)
    (bus_req && bus_wr && bus_region == 2'd2 && bus_addr == OFS_OE)
      |=> ((pad_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R2

  AST_OE_CLR_WIN: assert property (@(posedge clk) disable iff (rst || !live_q)
    (bus_req && bus_wr && bus_region == 2'd3 && bus_addr == OFS_OE)
      |=> ((pad_oe & $past(bus_wdata[NPINS-1:0])) == '0)); // R3

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst || !live_q)
    (|(edge_hit & clr_mask))
      |=> ((cause_q & $past(edge_hit & clr_mask)) == $past(edge_hit & clr_mask))); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst || !live_q)
    irq |-> $past(|(cause_q & evten_q))); // R10

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst || !live_q)
    (|(cause_q & evten_q)) |=> irq); // R10

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst || !live_q)
    (bus_rdata >> NPINS) == 32'd0); // R11
endmodule

bind gpio_ec_top gpio_ec_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_region(bus_region), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pad_oe(pad_oe), .irq(irq),
  .cause_q(cause_q), .evten_q(evten_q), .edge_hit(edge_hit), .clr_mask(clr_mask)
);

// File: tb/gpio_ec_top_tb_top.sv
module gpio_ec_top_tb_top;
  localparam int NP = 24;
  localparam logic [31:0] PM = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_region = 2'd0;
  logic [7:0] bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_oe = 0, m_do = 0, m_rise = 0, m_fall = 0, m_ev = 0;
  logic [31:0] got;

  always #10 clk = ~clk;

  gpio_ec_top #(.NPINS(NP)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_region(bus_region), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] rg, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_region = rg; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [1:0] rg, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_region = rg; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_out();
    return m_do & m_oe;
  endfunction

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", {8'd0, pad_oe}, 0);
    chk("R1 pad_out", {8'd0, pad_out}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    brd(0, 8'h00, got); chk("R1 rise", got, 0);
    brd(1, 8'h14, got); chk("R1 evten", got, 0);
    brd(2, 8'h04, got); chk("R1 dout", got, 0);

    // R11 upper bits
    bwr(2, 8'h00, 32'hFFFF_FFFF); m_oe = PM;
    brd(3, 8'h00, got); chk("R11 oe upper", got, PM);
    bwr(3, 8'h00, 32'hFFFF_FFFF); m_oe = 0;

    // random phase: set/clear windows and config regs, pads static low
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      int op;
      d  = $urandom;
      op = $urandom % 7;
      case (op)
        0: begin bwr(2, 8'h00, d); m_oe |= d & PM; end   // R2
        1: begin bwr(2, 8'h04, d); m_do |= d & PM; end   // R2
        2: begin bwr(3, 8'h00, d); m_oe &= ~d; end       // R3
        3: begin bwr(3, 8'h04, d); m_do &= ~d; end       // R3
        4: begin bwr(0, 8'h00, d); m_rise = d & PM; end  // R6
        5: begin bwr(0, 8'h04, d); m_fall = d & PM; end  // R6
        default: begin bwr(1, 8'h14, d); m_ev = d & PM; end // R8
      endcase
      chk("R2/R3 pad_oe", {8'd0, pad_oe}, m_oe);
      chk("R4 pad_out", {8'd0, pad_out}, exp_out());
      case ($urandom % 5)
        0: begin brd(0, 8'h00, got); chk("R12 rise readback", got, m_rise); end
        1: begin brd(0, 8'h04, got); chk("R12 fall readback", got, m_fall); end
        2: begin brd(1, 8'h14, got); chk("R11 evten readback", got, m_ev); end
        3: begin brd(2, 8'h00, got); chk("R3 oe readback", got, m_oe); end
        default: begin brd(3, 8'h04, got); chk("R3 dout readback", got, m_do); end
      endcase
    end

    // R12: rdata holds across idle cycles
    brd(2, 8'h04, got);
    idle(3);
    chk("R12 hold", bus_rdata, m_do);

    // R5 synchronizer latency
    bwr(0, 8'h00, 0); bwr(0, 8'h04, 0); bwr(1, 8'h18, 32'hFFFF_FFFF);
    @(negedge clk);
    pad_in = 24'hA5A5A5;
    bus_req = 1; bus_wr = 0; bus_region = 0; bus_addr = 8'h08;
    @(negedge clk);
    bus_req = 0;
    chk("R5 old level", bus_rdata, 0);
    idle(3);
    brd(0, 8'h08, got); chk("R5 new level", got, 32'h00A5A5A5);
    pad_in = '0;
    idle(5);

    // R6/R7 edges
    bwr(0, 8'h00, 32'h5);  // rise on 0 and 2
    bwr(0, 8'h04, 32'h6);  // fall on 1 and 2
    bwr(1, 8'h14, 32'h7);
    bwr(1, 8'h18, 32'hFFFF_FFFF);
    chk("R10 irq quiet", {31'd0, irq}, 0);
    @(negedge clk); pad_in = 24'h7;
    idle(5);
    brd(1, 8'h00, got); chk("R6 rise causes", got, 32'h5);
    chk("R10 irq high", {31'd0, irq}, 1);
    bwr(1, 8'h18, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 24'h0;
    idle(5);
    brd(1, 8'h00, got); chk("R7 fall causes both-edge", got, 32'h6);

    // R8 masking
    bwr(1, 8'h14, 32'h2);
    brd(1, 8'h00, got); chk("R8 masked", got, 32'h2);
    bwr(1, 8'h14, 32'h1);
    idle(2);
    brd(1, 8'h00, got); chk("R8 all masked", got, 0);
    chk("R10 irq masked low", {31'd0, irq}, 0);
    bwr(1, 8'h14, 32'h7);
    brd(1, 8'h00, got); chk("R8 latched under mask", got, 32'h6);

    // R9 write-1-to-clear
    bwr(1, 8'h18, 32'h2);
    brd(1, 8'h00, got); chk("R9 partial clear", got, 32'h4);
    bwr(1, 8'h18, 32'hFFFF_FFFF);
    idle(2);
    brd(1, 8'h00, got); chk("R9 clear all", got, 0);
    chk("R10 irq cleared", {31'd0, irq}, 0);

    // R9 edge beats same-cycle clear on bit 0 (rise enabled)
    @(negedge clk); pad_in = 24'h1;
    idle(5);
    @(negedge clk); pad_in = 24'h0;
    idle(5);
    brd(1, 8'h00, got); chk("R9 precondition", got, 32'h1);
    @(negedge clk); pad_in = 24'h1;          // N0
    @(negedge clk);                          // N1
    @(negedge clk);                          // N2: clear lands with edge
    bus_req = 1; bus_wr = 1; bus_region = 1; bus_addr = 8'h18; bus_wdata = 32'h1;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
    brd(1, 8'h00, got); chk("R9 edge wins", got, 32'h1);
    bwr(1, 8'h18, 32'h1);
    brd(1, 8'h00, got); chk("R9 clear without edge", got, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule